// File: doc/BRIEF.md
# Circular Audio Buffer Pointer Tracker

The block follows one circular audio buffer held in memory. Software programs the first and last byte addresses of the region, a watermark, and the read and write pointers. A playback build moves the read pointer forward each time the downstream consumer asks for a transfer. A capture build moves the write pointer forward each time the upstream producer delivers one. The memory data path itself is not part of the block.

Bit 31 of each pointer is a lap flag, not part of the address. When both pointers match the buffer is empty. When they differ only in the lap flag the buffer is full. From the two pointers the block derives the filled byte count and the current byte offset. It compares the free bytes (playback) or the filled bytes (capture) against the watermark, and raises a one-shot event for an interrupt block. A request that cannot be served raises an underrun or overrun pulse instead, and the pointer does not move.

Top module: `ringbuf_tracker`

## Requirements
- R1: After reset both pointers and all programmed values are zero, `empty_o` is 1, and `full_o`, `mark_evt_o` and `xrun_evt_o` are 0. The watermark event starts disarmed.
- R2: `empty_o` is 1 when the read and write pointers are equal. `full_o` is 1 when they differ only in bit 31. The two are never high together.
- R3: `fill_o` gives the filled byte count. It is write minus read address (bits 30:0) when the lap flags match. It is size minus (read minus write address) when the flags differ, where size = last - first + 1.
- R4: A `req_i` that is not blocked advances the active pointer by STEP_BYTES (4) on the next clock edge. The active pointer is read for playback and write for capture. The other pointer is unchanged.
- R5: When an advance would go beyond the programmed last address, the pointer reloads to the first address and bit 31 toggles.
- R6: `req_i` while blocked (playback empty, capture full) leaves the pointer unchanged and raises `xrun_evt_o` for exactly the following cycle. Otherwise `xrun_evt_o` stays 0.
- R7: When armed, `mark_evt_o` is 1 while the count (free bytes for playback, filled bytes for capture) is strictly greater than the watermark. A count equal to the watermark does not fire.
- R8: Once the watermark event has been seen for a cycle, it stays low until `rearm_i` is pulsed. `rearm_i` arms it for the next cycle.
- R9: A software write to a pointer appears on the next cycle and overrides a hardware advance of that pointer in the same cycle.
- R10: `offset_o` equals bits 30:0 of the active pointer minus bits 30:0 of the first address.
- R11: Write select codes are: 0 first address, 1 last address, 2 read pointer, 3 write pointer, 4 watermark. Codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Software write strobe |
| cfg_sel_i | input | 3 | Register select for the write |
| cfg_data_i | input | 32 | Write data |
| req_i | input | 1 | Transfer request (consumer for playback, producer for capture) |
| rearm_i | input | 1 | Re-enables the watermark event |
| rd_ptr_o | output | 32 | Read pointer, bit 31 is the lap flag |
| wr_ptr_o | output | 32 | Write pointer, bit 31 is the lap flag |
| fill_o | output | 32 | Filled byte count |
| offset_o | output | 31 | Byte offset of the active pointer from the first address |
| empty_o | output | 1 | Buffer empty |
| full_o | output | 1 | Buffer full |
| mark_evt_o | output | 1 | Watermark exceeded event |
| xrun_evt_o | output | 1 | Underrun (playback) or overrun (capture) pulse |

## Verification
A software write to the active pointer can land in the same cycle as a hardware advance of that pointer. A rearm can also arrive in the same cycle the watermark event is visible. The bench provokes the first case with a directed request plus write on a non-blocked buffer. Random refill and drain writes then collide with random requests. A second instance, built for capture, runs under the same stimulus. A reference model gives the write priority and applies the rearm before the disarm, and every output of both instances is compared to it after each cycle.

// File: rtl/ringbuf_pkg.sv
package ringbuf_pkg;
  typedef enum logic [2:0] {
    SEL_FIRST = 3'd0,
    SEL_LAST  = 3'd1,
    SEL_RD    = 3'd2,
    SEL_WR    = 3'd3,
    SEL_MARK  = 3'd4
  } cfg_sel_e;
endpackage

// File: rtl/ringbuf_step.sv
module ringbuf_step #(
  parameter int PTR_W = 32,
  parameter int STEP  = 4
) (
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [PTR_W-1:0] first_i,
  input  logic [PTR_W-1:0] last_i,
  output logic [PTR_W-1:0] nxt_o
);
  localparam int AW = PTR_W - 1;

  logic [AW:0] sum;
  logic        wrap;

  always_comb begin
    sum  = {1'b0, ptr_i[AW-1:0]} + (AW+1)'(STEP);
    wrap = sum > {1'b0, last_i[AW-1:0]};
    if (wrap) nxt_o = {~ptr_i[AW], first_i[AW-1:0]};
    else      nxt_o = {ptr_i[AW], sum[AW-1:0]};
  end
endmodule

// File: rtl/ringbuf_level.sv
module ringbuf_level #(
  parameter int PTR_W = 32
) (
  input  logic [PTR_W-1:0] rd_i,
  input  logic [PTR_W-1:0] wr_i,
  input  logic [PTR_W-1:0] first_i,
  input  logic [PTR_W-1:0] last_i,
  output logic [PTR_W-1:0] fill_o,
  output logic [PTR_W-1:0] free_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = PTR_W - 1;

  logic [PTR_W-1:0] size;
  logic [AW-1:0]    fwd_gap;
  logic [AW-1:0]    back_gap;
  logic             lap_eq;
  logic             addr_eq;

  always_comb begin
    size     = {1'b0, last_i[AW-1:0]} - {1'b0, first_i[AW-1:0]} + PTR_W'(1);
    fwd_gap  = wr_i[AW-1:0] - rd_i[AW-1:0];
    back_gap = rd_i[AW-1:0] - wr_i[AW-1:0];
    lap_eq   = rd_i[AW] == wr_i[AW];
    addr_eq  = rd_i[AW-1:0] == wr_i[AW-1:0];
    if (lap_eq) fill_o = {1'b0, fwd_gap};
    else        fill_o = size - {1'b0, back_gap};
    free_o  = size - fill_o;
    empty_o = lap_eq & addr_eq;
    full_o  = ~lap_eq & addr_eq;
  end
endmodule

// File: rtl/ringbuf_mark.sv
module ringbuf_mark #(
  parameter int PTR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PTR_W-1:0] count_i,
  input  logic [PTR_W-1:0] mark_i,
  input  logic             rearm_i,
  output logic             evt_o
);
  logic armed_q;
  logic exceed;

  assign exceed = count_i > mark_i;
  assign evt_o  = armed_q & exceed;

  // rearm wins over the disarm caused by a visible event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= rearm_i | (armed_q & ~exceed);
  end
endmodule

// File: rtl/ringbuf_tracker.sv
module ringbuf_tracker
  import ringbuf_pkg::*;
#(
  parameter int PTR_W      = 32,
  parameter int STEP_BYTES = 4,
  parameter bit PLAYBACK   = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_sel_i,
  input  logic [PTR_W-1:0] cfg_data_i,
  input  logic             req_i,
  input  logic             rearm_i,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] fill_o,
  output logic [PTR_W-2:0] offset_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             mark_evt_o,
  output logic             xrun_evt_o
);
  localparam int AW = PTR_W - 1;

  logic [PTR_W-1:0] first_q, last_q, rd_q, wr_q, mark_q;
  logic [PTR_W-1:0] act_ptr, act_nxt, fill, free, mark_cnt;
  logic             empty, full, blocked, adv, xrun_q;
  logic             adv_rd, adv_wr;

  generate
    if (PLAYBACK) begin : g_play
      assign act_ptr  = rd_q;
      assign blocked  = empty;
      assign mark_cnt = free;
      assign adv_rd   = adv;
      assign adv_wr   = 1'b0;
    end else begin : g_cap
      assign act_ptr  = wr_q;
      assign blocked  = full;
      assign mark_cnt = fill;
      assign adv_rd   = 1'b0;
      assign adv_wr   = adv;
    end
  endgenerate

  assign adv = req_i & ~blocked;

  ringbuf_step #(.PTR_W(PTR_W), .STEP(STEP_BYTES)) i_step (
    .ptr_i   (act_ptr),
    .first_i (first_q),
    .last_i  (last_q),
    .nxt_o   (act_nxt)
  );

  ringbuf_level #(.PTR_W(PTR_W)) i_level (
    .rd_i    (rd_q),
    .wr_i    (wr_q),
    .first_i (first_q),
    .last_i  (last_q),
    .fill_o  (fill),
    .free_o  (free),
    .empty_o (empty),
    .full_o  (full)
  );

  ringbuf_mark #(.PTR_W(PTR_W)) i_mark (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_i (mark_cnt),
    .mark_i  (mark_q),
    .rearm_i (rearm_i),
    .evt_o   (mark_evt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= '0;
      last_q  <= '0;
      mark_q  <= '0;
    end else if (cfg_we_i) begin
      if (cfg_sel_i == SEL_FIRST) first_q <= cfg_data_i;
      if (cfg_sel_i == SEL_LAST)  last_q  <= cfg_data_i;
      if (cfg_sel_i == SEL_MARK)  mark_q  <= cfg_data_i;
    end
  end

  // software write beats hardware advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              rd_q <= '0;
    else if (cfg_we_i && cfg_sel_i == SEL_RD) rd_q <= cfg_data_i;
    else if (adv_rd)                          rd_q <= act_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              wr_q <= '0;
    else if (cfg_we_i && cfg_sel_i == SEL_WR) wr_q <= cfg_data_i;
    else if (adv_wr)                          wr_q <= act_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) xrun_q <= 1'b0;
    else         xrun_q <= req_i & blocked;
  end

  assign rd_ptr_o   = rd_q;
  assign wr_ptr_o   = wr_q;
  assign fill_o     = fill;
  assign offset_o   = act_ptr[AW-1:0] - first_q[AW-1:0];
  assign empty_o    = empty;
  assign full_o     = full;
  assign xrun_evt_o = xrun_q;
endmodule

// File: rtl/ringbuf_tracker_chk.sv
module ringbuf_tracker_chk
  import ringbuf_pkg::*;
#(
  parameter int PTR_W    = 32,
  parameter bit PLAYBACK = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [2:0]       cfg_sel_i,
  input logic [PTR_W-1:0] cfg_data_i,
  input logic             req_i,
  input logic             rearm_i,
  input logic [PTR_W-1:0] rd_ptr_o,
  input logic [PTR_W-1:0] wr_ptr_o,
  input logic             empty_o,
  input logic             full_o,
  input logic             mark_evt_o,
  input logic             xrun_evt_o
);
  localparam logic [2:0] ACT_SEL = PLAYBACK ? SEL_RD : SEL_WR;

  logic [PTR_W-1:0] act;
  logic             blk, sw_act;

  assign act    = PLAYBACK ? rd_ptr_o : wr_ptr_o;
  assign blk    = PLAYBACK ? empty_o : full_o;
  assign sw_act = cfg_we_i && (cfg_sel_i == ACT_SEL);

  assert_not_both_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  assert_advance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !blk && !sw_act) |=> !$stable(act));

  assert_xrun_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && blk) |=> xrun_evt_o);

  assert_xrun_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && blk && !sw_act) |=> $stable(act));

  assert_no_xrun_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && blk) |=> !xrun_evt_o);

  assert_one_shot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_evt_o && !rearm_i) |=> !mark_evt_o);

  assert_sw_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_act |=> (act == $past(cfg_data_i)));
endmodule

bind ringbuf_tracker ringbuf_tracker_chk #(.PTR_W(PTR_W), .PLAYBACK(PLAYBACK)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_sel_i  (cfg_sel_i),
  .cfg_data_i (cfg_data_i),
  .req_i      (req_i),
  .rearm_i    (rearm_i),
  .rd_ptr_o   (rd_ptr_o),
  .wr_ptr_o   (wr_ptr_o),
  .empty_o    (empty_o),
  .full_o     (full_o),
  .mark_evt_o (mark_evt_o),
  .xrun_evt_o (xrun_evt_o)
);

// File: tb/test_ringbuf_tracker.sv
module test_ringbuf_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  sel = 3'd0;
  logic [31:0] data = '0;
  logic        req_p = 1'b0, req_c = 1'b0, rearm = 1'b0;

  logic [31:0] rd_p, wr_p, fill_p, rd_c, wr_c, fill_c;
  logic [30:0] off_p, off_c;
  logic        emp_p, ful_p, evt_p, xr_p, emp_c, ful_c, evt_c, xr_c;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_first = '0, m_last = '0, m_mark = '0;
  logic [31:0] m_rd_p = '0, m_wr_p = '0, m_rd_c = '0, m_wr_c = '0;
  logic        m_arm_p = 1'b0, m_arm_c = 1'b0, m_xr_p = 1'b0, m_xr_c = 1'b0;

  always #10 clk = ~clk;

  ringbuf_tracker #(.PLAYBACK(1'b1)) i_ringbuf_tracker (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_sel_i(sel), .cfg_data_i(data),
    .req_i(req_p), .rearm_i(rearm), .rd_ptr_o(rd_p), .wr_ptr_o(wr_p), .fill_o(fill_p),
    .offset_o(off_p), .empty_o(emp_p), .full_o(ful_p), .mark_evt_o(evt_p), .xrun_evt_o(xr_p));

  ringbuf_tracker #(.PLAYBACK(1'b0)) i_ringbuf_tracker_cap (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_sel_i(sel), .cfg_data_i(data),
    .req_i(req_c), .rearm_i(rearm), .rd_ptr_o(rd_c), .wr_ptr_o(wr_c), .fill_o(fill_c),
    .offset_o(off_c), .empty_o(emp_c), .full_o(ful_c), .mark_evt_o(evt_c), .xrun_evt_o(xr_c));

  function automatic logic [31:0] m_size();
    return {1'b0, m_last[30:0]} - {1'b0, m_first[30:0]} + 32'd1;
  endfunction

  function automatic logic [31:0] m_fill(input logic [31:0] r, input logic [31:0] w);
    logic [30:0] g;
    if (r[31] == w[31]) begin
      g = w[30:0] - r[30:0];
      return {1'b0, g};
    end
    g = r[30:0] - w[30:0];
    return m_size() - {1'b0, g};
  endfunction

  function automatic logic [31:0] m_adv(input logic [31:0] p);
    logic [31:0] s;
    s = {1'b0, p[30:0]} + 32'd4;
    if (s > {1'b0, m_last[30:0]}) return {~p[31], m_first[30:0]};
    return {p[31], s[30:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [30:0] o;
    check("R4 play rd", rd_p, m_rd_p);
    check("R9 play wr", wr_p, m_wr_p);
    check("R4 cap rd", rd_c, m_rd_c);
    check("R4 cap wr", wr_c, m_wr_c);
    check("R2 play empty", 32'(emp_p), 32'(m_rd_p == m_wr_p));
    check("R2 play full", 32'(ful_p), 32'((m_rd_p ^ m_wr_p) == 32'h8000_0000));
    check("R2 cap empty", 32'(emp_c), 32'(m_rd_c == m_wr_c));
    check("R2 cap full", 32'(ful_c), 32'((m_rd_c ^ m_wr_c) == 32'h8000_0000));
    check("R3 play fill", fill_p, m_fill(m_rd_p, m_wr_p));
    check("R3 cap fill", fill_c, m_fill(m_rd_c, m_wr_c));
    o = m_rd_p[30:0] - m_first[30:0];
    check("R10 play offset", 32'(off_p), 32'(o));
    o = m_wr_c[30:0] - m_first[30:0];
    check("R10 cap offset", 32'(off_c), 32'(o));
    check("R6 play xrun", 32'(xr_p), 32'(m_xr_p));
    check("R6 cap xrun", 32'(xr_c), 32'(m_xr_c));
    check("R7 play mark", 32'(evt_p),
          32'(m_arm_p && (m_size() - m_fill(m_rd_p, m_wr_p)) > m_mark));
    check("R7 cap mark", 32'(evt_c), 32'(m_arm_c && m_fill(m_rd_c, m_wr_c) > m_mark));
  endtask

  task automatic step(input logic rp, input logic rc, input logic ra,
                      input logic w, input logic [2:0] s, input logic [31:0] d);
    logic blk_p, blk_c, ex_p, ex_c;
    logic [31:0] n_rd_p, n_wr_c;
    req_p = rp; req_c = rc; rearm = ra; we = w; sel = s; data = d;
    blk_p  = m_rd_p == m_wr_p;
    blk_c  = (m_rd_c ^ m_wr_c) == 32'h8000_0000;
    ex_p   = (m_size() - m_fill(m_rd_p, m_wr_p)) > m_mark;
    ex_c   = m_fill(m_rd_c, m_wr_c) > m_mark;
    n_rd_p = (rp && !blk_p) ? m_adv(m_rd_p) : m_rd_p;
    n_wr_c = (rc && !blk_c) ? m_adv(m_wr_c) : m_wr_c;
    m_xr_p = rp && blk_p;
    m_xr_c = rc && blk_c;
    m_arm_p = ra || (m_arm_p && !ex_p);
    m_arm_c = ra || (m_arm_c && !ex_c);
    m_rd_p = n_rd_p;
    m_wr_c = n_wr_c;
    if (w) begin
      case (s)
        3'd0: m_first = d;
        3'd1: m_last  = d;
        3'd2: begin m_rd_p = d; m_rd_c = d; end
        3'd3: begin m_wr_p = d; m_wr_c = d; end
        3'd4: m_mark  = d;
        default: ;
      endcase
    end
    @(negedge clk);
    req_p = 1'b0; req_c = 1'b0; rearm = 1'b0; we = 1'b0;
    compare_all();
  endtask

  task automatic wreg(input logic [2:0] s, input logic [31:0] d);
    step(1'b0, 1'b0, 1'b0, 1'b1, s, d);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] snap_rd, snap_wr, snap_fill;
    logic [30:0] snap_off;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rd", rd_p, 32'h0);
    check("R1 wr", wr_c, 32'h0);
    check("R1 empty", 32'(emp_p), 32'd1);
    check("R1 full", 32'(ful_c), 32'd0);
    check("R1 mark evt", 32'({evt_p, evt_c}), 32'd0);
    check("R1 xrun", 32'({xr_p, xr_c}), 32'd0);

    // R11 program a 512 byte buffer and a 256 byte mark
    wreg(3'd0, 32'h0000_1000);
    wreg(3'd1, 32'h0000_11FF);
    wreg(3'd4, 32'h0000_0100);
    wreg(3'd2, 32'h0000_1000);
    wreg(3'd3, 32'h8000_1000);
    check("R2 both full", 32'({ful_p, ful_c}), 32'h3);
    check("R3 full level", fill_p, 32'd512);

    // R6 overrun on full capture buffer
    step(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, '0);
    check("R6 overrun pulse", 32'(xr_c), 32'd1);
    check("R6 overrun hold", wr_c, 32'h8000_1000);
    step(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, '0);
    check("R6 pulse ends", 32'(xr_c), 32'd0);

    // R7 playback drains to exactly the mark, then one past it
    for (int i = 0; i < 64; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, '0);
    check("R7 at mark silent", 32'(evt_p), 32'd0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, '0);
    check("R7 beyond mark fires", 32'(evt_p), 32'd1);
    for (int i = 0; i < 63; i++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, '0);
      if (i < 3) check("R8 stays quiet", 32'(evt_p), 32'd0);
    end
    check("R5 wrap to first", rd_p, 32'h8000_1000);
    check("R2 drained empty", 32'(emp_p), 32'd1);
    step(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, '0);
    check("R6 underrun pulse", 32'(xr_p), 32'd1);
    check("R6 underrun hold", rd_p, 32'h8000_1000);
    step(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, '0);
    check("R8 rearm fires", 32'(evt_p), 32'd1);

    // R9 software write collides with an advance
    wreg(3'd3, 32'h0000_1000);
    step(1'b1, 1'b0, 1'b0, 1'b1, 3'd2, 32'h8000_1100);
    check("R9 write wins", rd_p, 32'h8000_1100);
    check("R10 offset", 32'(off_p), 32'h100);

    // R11 unused select changes nothing
    snap_rd = rd_p; snap_wr = wr_p; snap_fill = fill_p; snap_off = off_p;
    wreg(3'd5, 32'h0000_1040);
    wreg(3'd7, 32'h8000_1080);
    check("R11 rd kept", rd_p, snap_rd);
    check("R11 wr kept", wr_p, snap_wr);
    check("R11 fill kept", fill_p, snap_fill);
    check("R11 offset kept", 32'(off_p), 32'(snap_off));

    // capture fills past the mark
    wreg(3'd2, 32'h0000_1000);
    step(1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 32'h0000_1000);
    for (int i = 0; i < 64; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, '0);
    check("R7 cap at mark silent", 32'(evt_c), 32'd0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, '0);
    check("R7 cap beyond mark", 32'(evt_c), 32'd1);
    check("R3 cap level", fill_c, 32'd260);

    // random traffic with refill and drain writes
    for (int i = 0; i < 3000; i++) begin
      logic        rp, rc, ra, w;
      logic [2:0]  s;
      logic [31:0] d;
      rp = ($urandom % 2) == 0;
      rc = ($urandom % 2) == 0;
      ra = ($urandom % 8) == 0;
      w  = ($urandom % 12) == 0;
      s  = 3'd0;
      d  = '0;
      if (w) begin
        case ($urandom % 4)
          0: begin s = 3'd3; d = m_rd_p ^ 32'h8000_0000; end
          1: begin s = 3'd2; d = m_wr_c; end
          2: begin
            s = 3'(2 + ($urandom % 2));
            d = 32'h1000 + (($urandom % 128) * 4);
            d[31] = 1'($urandom % 2);
          end
          default: begin s = 3'd4; d = ($urandom % 2) * 32'h100; end
        endcase
      end
      step(rp, rc, ra, w, s, d);
    end
    finish_run();
  end
endmodule